// File: doc/BRIEF.md
# Cross-Domain Doorbell Interrupt Flag

This block holds one pending-interrupt flag that links a local processor to an external host. The local CPU raises the flag to ring the host. The host clears the flag to acknowledge the ring. Each side has its own register write port, made of a strobe and one data bit, and both ports act on the same flag.

Both sides use write-one semantics, but the effect of a write depends on which side makes it:

- A CPU write of one can only set the flag, and only when the flag is clear.
- A host write of one can only clear the flag, and only when the flag is set.
- Any write that does not match the current state does nothing.

The flag is returned combinationally on a readback output for each side. Before ringing again, the CPU reads its readback and waits until the flag shows zero. An active-low interrupt pin to the host is driven straight from a register, so it cannot glitch. Both write ports run on one clock. Any synchronization of host strobes is done outside the block.

Top module: `xdom_doorbell`

## Requirements
- R1: A clock edge with `rst_n` low clears the flag. After that edge both readbacks are 0 and `irq_n` is 1.
- R2: When the flag is clear, an edge with `cpu_wr_en`=1 and `cpu_wr_val`=1 sets the flag. Both readbacks show 1 after that edge.
- R3: `irq_n` is 0 in every cycle where the flag is 1, and 1 in every cycle where the flag is 0.
- R4: When the flag is set, an edge with `host_wr_en`=1 and `host_wr_val`=1 clears the flag. `irq_n` returns to 1 after that edge.
- R5: A write strobe whose data bit is 0, from either side, leaves the flag unchanged.
- R6: When the flag is set, a CPU write of any value leaves it set. A second ring cannot be raised before the host acknowledges the first.
- R7: When the flag is clear, a host write of any value leaves it clear.
- R8: If a CPU write-1 and a host write-1 arrive on the same edge, the state before the edge decides the result. A set flag becomes clear, and a clear flag becomes set.
- R9: `cpu_rd_flag` and `host_rd_flag` both equal the flag in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both write ports |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_wr_en | input | 1 | CPU write strobe for the flag |
| cpu_wr_val | input | 1 | CPU write data bit |
| host_wr_en | input | 1 | Host write strobe for the flag |
| host_wr_val | input | 1 | Host write data bit |
| irq_n | output | 1 | Registered active-low interrupt to the host |
| cpu_rd_flag | output | 1 | Flag value on the CPU readback path |
| host_rd_flag | output | 1 | Flag value on the host readback path |

## Verification
The hardest case to reach is a host write and a CPU write that collide on the same edge while the flag is already in a given state, because the answer depends on the state before that edge. The bench first steers the flag into each state with an ordinary single-sided write. It then applies every one of the sixteen strobe/data combinations of the two ports from that state. It checks the flag, both readbacks and the pin against a one-line arithmetic model of the next state. A reset taken while a ring is pending is also covered.

// File: rtl/xdom_doorbell_pkg.sv
package xdom_doorbell_pkg;

   // One register write port: strobe plus the flag's data bit.
   typedef struct packed {
      logic en;
      logic val;
   } dbell_wr_t;

   // Pin level that signals a pending ring to the host.
   localparam logic IRQ_ASSERTED = 1'b0;

endpackage

// File: rtl/xdom_doorbell_next.sv
module xdom_doorbell_next
   import xdom_doorbell_pkg::*;
(
   input  logic      cur_flag,
   input  dbell_wr_t cpu_wr,
   input  dbell_wr_t host_wr,
   output logic      nxt_flag
);

   logic cpu_ring;
   logic host_ack;

   assign cpu_ring = cpu_wr.en  & cpu_wr.val;
   assign host_ack = host_wr.en & host_wr.val;

   // The current state chooses which side is listened to.
   always_comb begin
      if (cur_flag) nxt_flag = ~host_ack;
      else          nxt_flag = cpu_ring;
   end

endmodule

// File: rtl/xdom_doorbell_store.sv
module xdom_doorbell_store
   import xdom_doorbell_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic nxt_flag,
   output logic flag_q,
   output logic irq_n_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_q  <= 1'b0;
         irq_n_q <= ~IRQ_ASSERTED;
      end else begin
         flag_q  <= nxt_flag;
         irq_n_q <= nxt_flag ? IRQ_ASSERTED : ~IRQ_ASSERTED;
      end
   end

   // The pin register and the flag register must never disagree.
   assert_pin_tracks_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
      irq_n_q == ~flag_q);

   assert_reset_clears_R1: assert property (@(posedge clk)
      !rst_n |=> (!flag_q && irq_n_q));

endmodule

// File: rtl/xdom_doorbell.sv
module xdom_doorbell
   import xdom_doorbell_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic cpu_wr_en,
   input  logic cpu_wr_val,
   input  logic host_wr_en,
   input  logic host_wr_val,
   output logic irq_n,
   output logic cpu_rd_flag,
   output logic host_rd_flag
);

   dbell_wr_t cpu_wr;
   dbell_wr_t host_wr;
   logic      nxt_flag;
   logic      flag_q;
   logic      irq_n_q;

   assign cpu_wr  = '{en: cpu_wr_en,  val: cpu_wr_val};
   assign host_wr = '{en: host_wr_en, val: host_wr_val};

   xdom_doorbell_next u_next (
      .cur_flag (flag_q),
      .cpu_wr   (cpu_wr),
      .host_wr  (host_wr),
      .nxt_flag (nxt_flag)
   );

   xdom_doorbell_store u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .nxt_flag (nxt_flag),
      .flag_q   (flag_q),
      .irq_n_q  (irq_n_q)
   );

   assign irq_n        = irq_n_q;
   assign cpu_rd_flag  = flag_q;
   assign host_rd_flag = flag_q;

   assert_cpu_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_rd_flag && cpu_wr_en && cpu_wr_val) |=> cpu_rd_flag);

   assert_host_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd_flag && host_wr_en && host_wr_val) |=> (!host_rd_flag && irq_n));

   assert_zero_writes_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!(cpu_wr_en && cpu_wr_val) && !(host_wr_en && host_wr_val))
         |=> $stable(cpu_rd_flag));

   assert_set_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rd_flag && !(host_wr_en && host_wr_val)) |=> cpu_rd_flag);

   assert_clear_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!host_rd_flag && !(cpu_wr_en && cpu_wr_val)) |=> !host_rd_flag);

   assert_collision_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr_en && cpu_wr_val && host_wr_en && host_wr_val)
         |=> (cpu_rd_flag != $past(cpu_rd_flag)));

   assert_readbacks_agree_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rd_flag == host_rd_flag);

endmodule

// File: tb/xdom_doorbell_bench.sv
module xdom_doorbell_bench;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cpu_wr_en = 1'b0, cpu_wr_val = 1'b0;
   logic host_wr_en = 1'b0, host_wr_val = 1'b0;
   logic irq_n, cpu_rd_flag, host_rd_flag;

   int n_vec  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   xdom_doorbell u_xdom_doorbell (
      .clk(clk), .rst_n(rst_n),
      .cpu_wr_en(cpu_wr_en), .cpu_wr_val(cpu_wr_val),
      .host_wr_en(host_wr_en), .host_wr_val(host_wr_val),
      .irq_n(irq_n), .cpu_rd_flag(cpu_rd_flag), .host_rd_flag(host_rd_flag)
   );

   task automatic check_state(input logic exp_flag, input string req);
      n_vec++;
      if (cpu_rd_flag !== exp_flag || host_rd_flag !== exp_flag || irq_n !== ~exp_flag) begin
         n_fail++;
         $display("FAIL %s: cpu_rd=%b host_rd=%b irq_n=%b expected flag=%b irq_n=%b",
                  req, cpu_rd_flag, host_rd_flag, irq_n, exp_flag, ~exp_flag);
      end
   endtask

   // Drive on falling edge, one rising edge, sample at next falling edge.
   task automatic step(input logic ce, input logic cv, input logic he, input logic hv);
      cpu_wr_en = ce; cpu_wr_val = cv; host_wr_en = he; host_wr_val = hv;
      @(negedge clk);
      cpu_wr_en = 1'b0; cpu_wr_val = 1'b0; host_wr_en = 1'b0; host_wr_val = 1'b0;
   endtask

   initial begin
      @(negedge clk); @(negedge clk);
      check_state(1'b0, "R1 reset");
      rst_n = 1'b1;
      @(negedge clk);
      check_state(1'b0, "R3 idle pin");

      // Exhaustive: every start state times every write combination.
      for (int s = 0; s < 2; s++) begin
         for (int v = 0; v < 16; v++) begin
            logic ce, cv, he, hv, exp;
            string tag;
            // steer to start state
            if (s == 1) begin
               if (!cpu_rd_flag) step(1'b1, 1'b1, 1'b0, 1'b0);
            end else begin
               if (cpu_rd_flag) step(1'b0, 1'b0, 1'b1, 1'b1);
            end
            check_state(logic'(s), "R2/R4 steer");
            ce = v[3]; cv = v[2]; he = v[1]; hv = v[0];
            exp = (s == 1) ? logic'(!(he && hv)) : logic'(ce && cv);
            if (ce && cv && he && hv)           tag = "R8 collision";
            else if (s == 1 && he && hv)        tag = "R4 host ack";
            else if (s == 0 && ce && cv)        tag = "R2 cpu ring";
            else if (s == 1 && ce)              tag = "R6 set holds";
            else if (s == 0 && he)              tag = "R7 clear holds";
            else                                tag = "R5 zero write";
            step(ce, cv, he, hv);
            check_state(exp, tag);
            check_state(exp, "R9 R3 readback/pin");
         end
      end

      // Reset while a ring is pending.
      if (!cpu_rd_flag) step(1'b1, 1'b1, 1'b0, 1'b0);
      check_state(1'b1, "R2 pre-reset");
      rst_n = 1'b0;
      cpu_wr_en = 1'b1; cpu_wr_val = 1'b1;
      @(negedge clk);
      check_state(1'b0, "R1 reset pending");
      cpu_wr_en = 1'b0; cpu_wr_val = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      check_state(1'b0, "R1 after release");
      done = 1'b1;
   end

   initial begin
      fork
         begin wait (done); end
         begin
            repeat (5000) @(posedge clk);
            n_vec++; n_fail++;
            $display("FAIL watchdog: run incomplete, expected done=1 got 0");
         end
      join_any
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

endmodule